// File: doc/BRIEF.md
# DRAM Command Sequencer with Open-Row Tracking

This block sits between a request source and the pin-level command and address bus of a DDR4-class DRAM. Each request arrives already split into bank group, bank, row and column fields. It also carries a read/write flag, an auto-precharge flag and a burst-chop flag. The sequencer turns each request into the shortest legal run of commands. A closed bank gets an activate and then a column command. An open bank whose row matches gets the column command alone. An open bank holding another row gets a precharge, an activate and then the column command.

Per-bank state records whether the bank is open, which row it holds, and a countdown that enforces the fixed minimum gaps. These gaps are activate to column command, and precharge or auto-precharge to the next activate. One shared countdown enforces the column-to-column gap. At most one command leaves per clock. Every pin is registered, and the chip select stays high in any cycle that carries no command. The request source holds its fields stable while `req_valid` is high. The request is taken in the cycle `req_ready` is high, and the matching column command appears on the pins one cycle later.

Top module: `dram_cmd_seq`

## Requirements
- R1: After reset and in every cycle with no command, `ddr_select_n`, `ddr_activate_n` and all three bits of `ddr_cmd_hi` are high, and no command appears while `req_valid` is low.
- R2: An activate drives `ddr_select_n` and `ddr_activate_n` low. Row bits 16, 15 and 14 go on `ddr_cmd_hi[2]`, `[1]` and `[0]`, row bits 13..0 go on `ddr_addr`, and the bank group and bank go on `ddr_bgrp` and `ddr_bank`.
- R3: A column command drives `ddr_select_n` low and `ddr_activate_n` high, with `ddr_cmd_hi` = 3'b101 for a read and 3'b100 for a write. The column goes on `ddr_addr[9:0]`. `ddr_addr[10]` is the auto-precharge flag. `ddr_addr[12]` is high for a burst of eight and low for a chopped burst of four. Bits 11 and 13 are low.
- R4: A precharge drives `ddr_select_n` low, `ddr_activate_n` high and `ddr_cmd_hi` = 3'b010, with `ddr_addr[10]` low so that only the addressed bank closes.
- R5: A request to a closed bank produces an activate followed by the column command, with no precharge.
- R6: A request to the row already open in its bank produces the column command alone.
- R7: A request to an open bank holding a different row produces a precharge, an activate and the column command, in that order.
- R8: A column command with auto-precharge leaves its bank closed, so the next request to that bank starts with an activate and no precharge.
- R9: Open-row state is kept per bank (bank index = {bank group, bank}); activating one bank does not disturb the row held open in another.
- R10: A column command to a bank follows that bank's activate by at least `T_RCD` cycles, and exactly `T_RCD` when nothing else delays it.
- R11: An activate to a bank follows that bank's precharge or auto-precharge column command by at least `T_RP` cycles, and exactly `T_RP` when the request is already waiting.
- R12: Successive column commands are at least `T_CCD` cycles apart, and exactly `T_CCD` when the next request is already waiting.
- R13: `req_ready` is high only while `req_valid` is high, and only in the cycle the column command is decided. It stays low during every activate, precharge and gap cycle. The column command shows on the pins in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present; fields held stable while high |
| req_ready | output | 1 | Request taken this cycle (its column command is issued) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bg | input | BG_BITS | Bank group (1 bit for x16, 2 bits otherwise) |
| req_ba | input | 2 | Bank within the group |
| req_row | input | ROW_BITS | Row address |
| req_col | input | 10 | Starting column |
| req_ap | input | 1 | Close the bank after this access |
| req_chop | input | 1 | 1 = chopped burst of four, 0 = burst of eight |
| ddr_select_n | output | 1 | Chip select, low only in command cycles |
| ddr_activate_n | output | 1 | Activate strobe, low only for an activate |
| ddr_cmd_hi | output | 3 | Command code, or row bits 16..14 during an activate |
| ddr_bgrp | output | BG_BITS | Bank group pins |
| ddr_bank | output | 2 | Bank pins |
| ddr_addr | output | 14 | Address pins A13..A0 |

## Verification
The bench builds the block for a x8 device, which gives two bank-group bits and sixteen tracked banks, with `T_RCD` = 5, `T_RP` = 3 and `T_CCD` = 4. These three gaps differ from one another and are all above one. Each measured distance between commands therefore pins down which countdown produced it, and an off-by-one in a load value shows up as a wrong distance. The wide bank group lets one scenario hold rows open in two banks of different groups at once, and then confirm that a return to the first bank is a hit.

// File: rtl/dcs_pkg.sv
// Shared types and fixed pin geometry for the DRAM command sequencer.
// Assumes a DDR4-style bus: 14 plain address pins plus three dual-use
// command pins that carry the upper row bits during an activate.
package dcs_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_PRE = 3'd2,
        CMD_RD  = 3'd3,
        CMD_WR  = 3'd4
    } dcs_cmd_e;

    localparam int PIN_ROW_BITS = 17;  // row width carried by the pins
    localparam int ADDR_PINS    = 14;  // A13..A0
    localparam int COL_BITS     = 10;  // column on A9..A0
    localparam int BA_BITS      = 2;
    localparam int AP_PIN       = 10;  // auto-precharge flag position
    localparam int BL8_PIN      = 12;  // high = burst of eight

    // command codes on the three dual-use pins when activate is high
    localparam logic [2:0] HI_PRE = 3'b010;
    localparam logic [2:0] HI_RD  = 3'b101;
    localparam logic [2:0] HI_WR  = 3'b100;
    localparam logic [2:0] HI_IDLE = 3'b111;

endpackage

// File: rtl/dcs_gap_timer.sv
// Down-counter that enforces a minimum number of cycles between commands.
// Loading value V makes `expired` rise V cycles later; a load of 0 leaves it
// expired from the next cycle. Assumes load values fit in CNT_W bits.
module dcs_gap_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // count down to zero, restarting on load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/dcs_bank_table.sv
// Per-bank open-row table. Each bank keeps an open flag, the open row and a
// gap timer that gates the bank's next command. The timer is loaded with
// T_RCD-1 on an activate and with T_RP-1 on a precharge or on a column
// command with auto-precharge. Assumes one update per cycle.
module dcs_bank_table
    import dcs_pkg::*;
#(
    parameter int IDX_W    = 4,
    parameter int ROW_BITS = 17,
    parameter int CNT_W    = 4,
    parameter int T_RCD    = 4,
    parameter int T_RP     = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  dcs_cmd_e            upd_cmd,
    input  logic                upd_ap,
    input  logic [IDX_W-1:0]    upd_idx,
    input  logic [ROW_BITS-1:0] upd_row,
    input  logic [IDX_W-1:0]    look_idx,
    output logic                look_open,
    output logic [ROW_BITS-1:0] look_row,
    output logic                look_ready
);

    localparam int NB = 1 << IDX_W;

    logic                open_q [NB];
    logic [ROW_BITS-1:0] row_q  [NB];
    logic [NB-1:0]       rdy;

    // a bank closes on precharge or on a column command asking for it
    logic closing;
    assign closing = (upd_cmd == CMD_PRE) ||
                     (((upd_cmd == CMD_RD) || (upd_cmd == CMD_WR)) && upd_ap);

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic             hit_b;
        logic             tload;
        logic [CNT_W-1:0] tval;

        assign hit_b = (upd_idx == IDX_W'(b));
        assign tload = hit_b && ((upd_cmd == CMD_ACT) || closing);
        assign tval  = (upd_cmd == CMD_ACT) ? CNT_W'(T_RCD - 1) : CNT_W'(T_RP - 1);

        // track the open flag and open row of this bank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_q[b] <= 1'b0;
                row_q[b]  <= '0;
            end else if (hit_b && upd_cmd == CMD_ACT) begin
                open_q[b] <= 1'b1;
                row_q[b]  <= upd_row;
            end else if (hit_b && closing) begin
                open_q[b] <= 1'b0;
            end
        end

        dcs_gap_timer #(.CNT_W(CNT_W)) i_gap (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (tload),
            .load_val (tval),
            .expired  (rdy[b])
        );
    end

    assign look_open  = open_q[look_idx];
    assign look_row   = row_q[look_idx];
    assign look_ready = rdy[look_idx];

endmodule

// File: rtl/dcs_pin_driver.sv
// Registered encoder from an internal command to the DRAM pins. A no-op
// cycle deselects the device and parks the strobes high. Assumes the
// caller presents at most one command per cycle.
module dcs_pin_driver
    import dcs_pkg::*;
#(
    parameter int BG_BITS = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  dcs_cmd_e                cmd,
    input  logic [BG_BITS-1:0]      bg,
    input  logic [BA_BITS-1:0]      ba,
    input  logic [PIN_ROW_BITS-1:0] row,
    input  logic [COL_BITS-1:0]     col,
    input  logic                    ap,
    input  logic                    chop,
    output logic                    sel_n,
    output logic                    act_n,
    output logic [2:0]              cmd_hi,
    output logic [BG_BITS-1:0]      pin_bg,
    output logic [BA_BITS-1:0]      pin_ba,
    output logic [ADDR_PINS-1:0]    pin_addr
);

    logic                 n_sel, n_act;
    logic [2:0]           n_hi;
    logic [BG_BITS-1:0]   n_bg;
    logic [BA_BITS-1:0]   n_ba;
    logic [ADDR_PINS-1:0] n_addr;

    // build the pin pattern for the chosen command
    always_comb begin
        n_sel  = 1'b1;
        n_act  = 1'b1;
        n_hi   = HI_IDLE;
        n_bg   = '0;
        n_ba   = '0;
        n_addr = '0;
        case (cmd)
            CMD_ACT: begin
                n_sel  = 1'b0;
                n_act  = 1'b0;
                n_hi   = row[PIN_ROW_BITS-1 -: 3];
                n_addr = row[ADDR_PINS-1:0];
                n_bg   = bg;
                n_ba   = ba;
            end
            CMD_PRE: begin
                n_sel = 1'b0;
                n_hi  = HI_PRE;
                n_bg  = bg;
                n_ba  = ba;
            end
            CMD_RD, CMD_WR: begin
                n_sel                  = 1'b0;
                n_hi                   = (cmd == CMD_WR) ? HI_WR : HI_RD;
                n_addr[COL_BITS-1:0]   = col;
                n_addr[AP_PIN]         = ap;
                n_addr[BL8_PIN]        = ~chop;
                n_bg                   = bg;
                n_ba                   = ba;
            end
            default: ;
        endcase
    end

    // register every pin so the bus changes only at the clock edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_n    <= 1'b1;
            act_n    <= 1'b1;
            cmd_hi   <= HI_IDLE;
            pin_bg   <= '0;
            pin_ba   <= '0;
            pin_addr <= '0;
        end else begin
            sel_n    <= n_sel;
            act_n    <= n_act;
            cmd_hi   <= n_hi;
            pin_bg   <= n_bg;
            pin_ba   <= n_ba;
            pin_addr <= n_addr;
        end
    end

endmodule

// File: rtl/dram_cmd_seq.sv
// DRAM command sequencer. For the request at its input it chooses one
// command per cycle from the state of the addressed bank: a column command
// on a row hit, a precharge on a row miss, an activate on a closed bank.
// Each is held back until its gap timer has expired. The request is taken
// (req_ready high) in the cycle its column command is chosen. Assumes the
// requester holds the fields stable while req_valid is high, and that every
// gap parameter is at least 1.
module dram_cmd_seq
    import dcs_pkg::*;
#(
    parameter int DEV_WIDTH = 8,
    parameter int ROW_BITS  = 17,
    parameter int T_RCD     = 4,
    parameter int T_RP      = 4,
    parameter int T_CCD     = 2,
    localparam int BG_BITS  = (DEV_WIDTH == 16) ? 1 : 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [BG_BITS-1:0]   req_bg,
    input  logic [1:0]           req_ba,
    input  logic [ROW_BITS-1:0]  req_row,
    input  logic [9:0]           req_col,
    input  logic                 req_ap,
    input  logic                 req_chop,
    output logic                 ddr_select_n,
    output logic                 ddr_activate_n,
    output logic [2:0]           ddr_cmd_hi,
    output logic [BG_BITS-1:0]   ddr_bgrp,
    output logic [1:0]           ddr_bank,
    output logic [13:0]          ddr_addr
);

    localparam int IDX_W  = BG_BITS + BA_BITS;
    localparam int T_MAX  = (T_RCD > T_RP) ? ((T_RCD > T_CCD) ? T_RCD : T_CCD)
                                           : ((T_RP  > T_CCD) ? T_RP  : T_CCD);
    localparam int CNT_W  = $clog2(T_MAX + 1);

    logic [IDX_W-1:0]    bank_idx;
    logic                bank_open;
    logic [ROW_BITS-1:0] bank_row;
    logic                bank_rdy;
    logic                col_rdy;
    logic                row_hit;
    logic                col_issue;
    dcs_cmd_e            nxt_cmd;

    assign bank_idx = {req_bg, req_ba};
    assign row_hit  = bank_open && (bank_row == req_row);

    // choose this cycle's command for the waiting request
    always_comb begin
        nxt_cmd   = CMD_NOP;
        req_ready = 1'b0;
        if (req_valid) begin
            if (row_hit) begin
                if (bank_rdy && col_rdy) begin
                    nxt_cmd   = req_write ? CMD_WR : CMD_RD;
                    req_ready = 1'b1;
                end
            end else if (bank_open) begin
                if (bank_rdy) nxt_cmd = CMD_PRE;
            end else if (bank_rdy) begin
                nxt_cmd = CMD_ACT;
            end
        end
    end

    assign col_issue = (nxt_cmd == CMD_RD) || (nxt_cmd == CMD_WR);

    dcs_bank_table #(
        .IDX_W    (IDX_W),
        .ROW_BITS (ROW_BITS),
        .CNT_W    (CNT_W),
        .T_RCD    (T_RCD),
        .T_RP     (T_RP)
    ) i_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_cmd    (nxt_cmd),
        .upd_ap     (req_ap),
        .upd_idx    (bank_idx),
        .upd_row    (req_row),
        .look_idx   (bank_idx),
        .look_open  (bank_open),
        .look_row   (bank_row),
        .look_ready (bank_rdy)
    );

    dcs_gap_timer #(.CNT_W(CNT_W)) i_col_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (col_issue),
        .load_val (CNT_W'(T_CCD - 1)),
        .expired  (col_rdy)
    );

    dcs_pin_driver #(.BG_BITS(BG_BITS)) i_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (nxt_cmd),
        .bg       (req_bg),
        .ba       (req_ba),
        .row      (PIN_ROW_BITS'(req_row)),
        .col      (req_col),
        .ap       (req_ap),
        .chop     (req_chop),
        .sel_n    (ddr_select_n),
        .act_n    (ddr_activate_n),
        .cmd_hi   (ddr_cmd_hi),
        .pin_bg   (ddr_bgrp),
        .pin_ba   (ddr_bank),
        .pin_addr (ddr_addr)
    );

endmodule

// File: rtl/dcs_checker.sv
// Protocol checker for dram_cmd_seq. It watches only the ports and keeps a
// shadow of which banks are open, decoded from the pins, plus saturating
// counters of the cycles since each bank's last activate and last close and
// since the last column command. Assumes gap parameters below 255.
module dcs_checker #(
    parameter int BG_BITS = 2,
    parameter int T_RCD   = 4,
    parameter int T_RP    = 4,
    parameter int T_CCD   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic               sel_n,
    input logic               act_n,
    input logic [2:0]         cmd_hi,
    input logic [BG_BITS-1:0] pin_bg,
    input logic [1:0]         pin_ba,
    input logic               ap_pin
);

    localparam int IDX_W = BG_BITS + 2;
    localparam int NB    = 1 << IDX_W;

    logic             is_act, is_pre, is_col;
    logic [IDX_W-1:0] idx;
    logic             sh_open   [NB];
    logic [7:0]       since_act [NB];
    logic [7:0]       since_cls [NB];
    logic [7:0]       since_col;

    assign is_act = !sel_n && !act_n;
    assign is_pre = !sel_n && act_n && (cmd_hi == 3'b010);
    assign is_col = !sel_n && act_n && cmd_hi[2] && !cmd_hi[1];
    assign idx    = {pin_bg, pin_ba};

    // shadow bank state and gap counters from the observed pins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_col <= 8'hFF;
            for (int b = 0; b < NB; b++) begin
                sh_open[b]   <= 1'b0;
                since_act[b] <= 8'hFF;
                since_cls[b] <= 8'hFF;
            end
        end else begin
            since_col <= is_col ? 8'd1 : ((since_col == 8'hFF) ? since_col : since_col + 8'd1);
            for (int b = 0; b < NB; b++) begin
                if (since_act[b] != 8'hFF) since_act[b] <= since_act[b] + 8'd1;
                if (since_cls[b] != 8'hFF) since_cls[b] <= since_cls[b] + 8'd1;
            end
            if (is_act) begin
                sh_open[idx]   <= 1'b1;
                since_act[idx] <= 8'd1;
            end
            if (is_pre || (is_col && ap_pin)) begin
                sh_open[idx]   <= 1'b0;
                since_cls[idx] <= 8'd1;
            end
        end
    end

    a_r10_act_to_col: assert property (@(posedge clk) disable iff (!rst_n)
        is_col |-> (int'(since_act[idx]) >= T_RCD));

    a_r11_close_to_act: assert property (@(posedge clk) disable iff (!rst_n)
        is_act |-> (int'(since_cls[idx]) >= T_RP));

    a_r12_col_gap: assert property (@(posedge clk) disable iff (!rst_n)
        is_col |-> (int'(since_col) >= T_CCD));

    a_r5_act_closed_only: assert property (@(posedge clk) disable iff (!rst_n)
        is_act |-> !sh_open[idx]);

    a_r6_col_open_only: assert property (@(posedge clk) disable iff (!rst_n)
        is_col |-> sh_open[idx]);

    a_r7_pre_open_only: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> sh_open[idx]);

    a_r13_accept_then_column: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> is_col);

    a_r13_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> req_valid);

    a_r1_quiet_without_request: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> sel_n);

endmodule

bind dram_cmd_seq dcs_checker #(
    .BG_BITS (BG_BITS),
    .T_RCD   (T_RCD),
    .T_RP    (T_RP),
    .T_CCD   (T_CCD)
) i_dcs_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .sel_n     (ddr_select_n),
    .act_n     (ddr_activate_n),
    .cmd_hi    (ddr_cmd_hi),
    .pin_bg    (ddr_bgrp),
    .pin_ba    (ddr_bank),
    .ap_pin    (ddr_addr[10])
);

// File: tb/test_dram_cmd_seq.sv
// Directed bench for dram_cmd_seq: one task per scenario, each checking the
// command log captured from the pins.
module test_dram_cmd_seq;

    localparam int CLK_PERIOD = 10;
    localparam int DEV_WIDTH  = 8;
    localparam int T_RCD      = 5;
    localparam int T_RP       = 3;
    localparam int T_CCD      = 4;
    localparam int WATCHDOG   = 5000;

    localparam int K_ACT = 1, K_PRE = 2, K_RD = 3, K_WR = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_bg = '0;
    logic [1:0]  req_ba = '0;
    logic [16:0] req_row = '0;
    logic [9:0]  req_col = '0;
    logic        req_ap = 1'b0;
    logic        req_chop = 1'b0;
    logic        ddr_select_n, ddr_activate_n;
    logic [2:0]  ddr_cmd_hi;
    logic [1:0]  ddr_bgrp, ddr_bank;
    logic [13:0] ddr_addr;

    dram_cmd_seq #(
        .DEV_WIDTH (DEV_WIDTH),
        .ROW_BITS  (17),
        .T_RCD     (T_RCD),
        .T_RP      (T_RP),
        .T_CCD     (T_CCD)
    ) i_dram_cmd_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_bg(req_bg), .req_ba(req_ba), .req_row(req_row),
        .req_col(req_col), .req_ap(req_ap), .req_chop(req_chop),
        .ddr_select_n(ddr_select_n), .ddr_activate_n(ddr_activate_n),
        .ddr_cmd_hi(ddr_cmd_hi), .ddr_bgrp(ddr_bgrp), .ddr_bank(ddr_bank),
        .ddr_addr(ddr_addr)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int  cyc = 0;
    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 0;

    // command log filled from the pins at every falling edge
    int          n_log = 0;
    int          log_kind [16];
    int          log_cyc  [16];
    int          log_bank [16];
    logic [13:0] log_addr [16];
    logic [2:0]  log_hi   [16];

    always @(negedge clk) begin
        if (rst_n && !ddr_select_n && n_log < 16) begin
            if (!ddr_activate_n)              log_kind[n_log] = K_ACT;
            else if (ddr_cmd_hi == 3'b010)    log_kind[n_log] = K_PRE;
            else if (ddr_cmd_hi == 3'b101)    log_kind[n_log] = K_RD;
            else if (ddr_cmd_hi == 3'b100)    log_kind[n_log] = K_WR;
            else                              log_kind[n_log] = 0;
            log_cyc[n_log]  = cyc;
            log_bank[n_log] = {ddr_bgrp, ddr_bank};
            log_addr[n_log] = ddr_addr;
            log_hi[n_log]   = ddr_cmd_hi;
            n_log++;
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    endtask

    // cycle count and watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == WATCHDOG && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            summary();
            $finish;
        end
    end

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // present one request, wait for it to be taken, let its column command land
    task automatic send(input bit wr, input int bank, input logic [16:0] row,
                        input logic [9:0] col, input bit ap, input bit chop,
                        output int low_cycles);
        n_log = 0;
        @(negedge clk);
        req_write = wr;
        req_bg    = 2'(bank >> 2);
        req_ba    = 2'(bank);
        req_row   = row;
        req_col   = col;
        req_ap    = ap;
        req_chop  = chop;
        req_valid = 1'b1;
        low_cycles = 0;
        #1;
        while (!req_ready) begin
            low_cycles++;
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        req_valid = 1'b0;
        #2;
    endtask

    function automatic logic [13:0] col_pins(input logic [9:0] col, input bit ap, input bit chop);
        logic [13:0] a = '0;
        a[9:0] = col;
        a[10]  = ap;
        a[12]  = ~chop;
        return a;
    endfunction

    task automatic t_reset();
        @(negedge clk);
        check("R1", "select after reset", ddr_select_n, 1);
        check("R1", "activate after reset", ddr_activate_n, 1);
        check("R1", "cmd pins after reset", ddr_cmd_hi, 3'b111);
        check("R13", "ready without valid", req_ready, 0);
    endtask

    task automatic t_idle();
        n_log = 0;
        repeat (8) @(negedge clk);
        #1;
        check("R1", "commands while idle", n_log, 0);
        check("R1", "select while idle", ddr_select_n, 1);
    endtask

    task automatic t_closed_read();
        int lc;
        logic [16:0] row = 17'h1A5C3;
        send(0, 5, row, 10'h2F3, 0, 0, lc);
        check("R5", "command count closed bank", n_log, 2);
        check("R2", "activate kind", log_kind[0], K_ACT);
        check("R2", "activate upper row pins", log_hi[0], row[16:14]);
        check("R2", "activate low row pins", log_addr[0], row[13:0]);
        check("R2", "activate bank", log_bank[0], 5);
        check("R3", "read kind", log_kind[1], K_RD);
        check("R3", "read code pins", log_hi[1], 3'b101);
        check("R3", "read address pins BL8", log_addr[1], col_pins(10'h2F3, 0, 0));
        check("R10", "activate to read gap", log_cyc[1] - log_cyc[0], T_RCD);
        check("R13", "ready low cycles", lc, T_RCD);
    endtask

    task automatic t_hit_write();
        int lc;
        send(1, 5, 17'h1A5C3, 10'h010, 0, 1, lc);
        check("R6", "command count on hit", n_log, 1);
        check("R3", "write kind", log_kind[0], K_WR);
        check("R3", "write code pins", log_hi[0], 3'b100);
        check("R3", "write address pins BC4", log_addr[0], col_pins(10'h010, 0, 1));
    endtask

    task automatic t_back_to_back();
        int lc, c0;
        send(0, 5, 17'h1A5C3, 10'h100, 0, 0, lc);
        c0 = log_cyc[0];
        send(0, 5, 17'h1A5C3, 10'h108, 0, 0, lc);
        check("R6", "second hit single command", n_log, 1);
        check("R12", "column to column gap", log_cyc[0] - c0, T_CCD);
    endtask

    task automatic t_miss();
        int lc;
        send(0, 5, 17'h00123, 10'h007, 0, 0, lc);
        check("R7", "command count on miss", n_log, 3);
        check("R7", "first is precharge", log_kind[0], K_PRE);
        check("R4", "precharge A10 low", log_addr[0][10], 0);
        check("R4", "precharge bank", log_bank[0], 5);
        check("R7", "second is activate", log_kind[1], K_ACT);
        check("R2", "activate new row", {log_hi[1], log_addr[1]}, 17'h00123);
        check("R7", "third is read", log_kind[2], K_RD);
        check("R11", "precharge to activate gap", log_cyc[1] - log_cyc[0], T_RP);
        check("R10", "activate to read gap after miss", log_cyc[2] - log_cyc[1], T_RCD);
    endtask

    task automatic t_auto_precharge();
        int lc, c0;
        send(0, 5, 17'h00123, 10'h040, 1, 0, lc);
        check("R3", "auto-precharge A10 high", log_addr[0][10], 1);
        c0 = log_cyc[0];
        send(0, 5, 17'h00123, 10'h048, 0, 0, lc);
        check("R8", "command count after auto-precharge", n_log, 2);
        check("R8", "reopen by activate, no precharge", log_kind[0], K_ACT);
        check("R11", "auto-precharge to activate gap", log_cyc[0] - c0, T_RP);
    endtask

    task automatic t_banks();
        int lc;
        send(0, 12, 17'h0ABCD, 10'h001, 0, 0, lc);
        check("R9", "other bank activates", log_kind[0], K_ACT);
        check("R9", "other bank index", log_bank[0], 12);
        send(1, 5, 17'h00123, 10'h002, 0, 0, lc);
        check("R9", "first bank still open", n_log, 1);
        check("R9", "first bank hit is write", log_kind[0], K_WR);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_idle();
        t_closed_read();
        t_hit_write();
        t_back_to_back();
        t_miss();
        t_auto_precharge();
        t_banks();
        repeat (4) @(negedge clk);
        done = 1;
        summary();
        $finish;
    end

endmodule